// File: doc/BRIEF.md
# Serial SAR ADC Interface Sequencer

This block is the digital control half of an 8-bit successive-approximation converter driven over a four-wire serial link. A host lowers the active-low select line and clocks a frame through it. The block first waits for a start bit on the serial input. It then captures a short channel address and decodes it into one-hot enables for the positive and negative inputs of the analogue selector. The negative side goes either to a paired neighbour channel or to the common terminal.

After one settling cycle the block runs the bit-by-bit approximation. Each cycle it drives a trial code to an external DAC and reads back one comparator decision. Every decided bit goes straight onto the serial output, so the host receives the result MSB first while the conversion is still running. A busy line is raised for the conversion. Once the code is complete, a replay of the same code is shifted out LSB first. In the eight-input variant, a hold input can delay the start of that replay. After the replay the serial output is driven low until the host raises select again. The data output and the busy line each have their own output-enable, and both enables drop whenever select is high.

Timing is single-edge: events that would fall half a period apart in an analogue-paced part land here on the next rising edge. A one-cycle done pulse carries the parallel result.

Top module: `adc_serial_seq`

## Requirements
- R1: Synchronous reset clears every output. The DAC code, the input enables, the common select, the data output and its enable, the busy line and its enable, done and the result all read 0.
- R2: With select low, DI is sampled on each rising edge. Leading zeros are skipped. The first 1 is the start bit, and the next 1+log2(NUM_CH) samples form the address (4 bits for 8 inputs, 3 bits for 4 inputs).
- R3: The address bits arrive in this order: mode (1 = single-ended, 0 = differential), then odd, then the select bits MSB first. The positive input is channel {select,odd}. In differential mode the negative input is channel {select,~odd}. In single-ended mode the negative input is the common terminal (minus_com=1 with minus_en all zero). The enables are valid from the cycle after the last address bit.
- R4: After the last address bit there is one settling cycle with busy low. Busy is then high for exactly 8 cycles. DI has no effect from the settling cycle until the frame ends.
- R5: The first trial code is 0x80. On each step the current bit is kept if the comparator input is 1 (input at or above the trial) and cleared otherwise. The next lower bit is then tried.
- R6: Each decided bit appears on the data output in the cycle after its decision, MSB first. The data output enable rises with the first decided bit.
- R7: Done pulses for one cycle, together with the falling edge of busy, and the result output then equals the final code. A negative differential input yields 0x00.
- R8: After the MSB-first stream, bit 0 stays on the output. Bits 1 to 7 then follow, one per cycle. In the eight-input variant, holding the hold input high keeps bit 0 on the output until the hold input is sampled low.
- R9: After bit 7 of the replay, the data output is 0 and stays 0 (still enabled) until select rises.
- R10: Select high at any edge aborts the frame. From the next cycle both output enables, busy and the input enables are 0. A following frame then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| di | input | 1 | Serial start and address input |
| se | input | 1 | Hold for the LSB-first replay (eight-input variant) |
| comp | input | 1 | Comparator decision, 1 when the input is at or above the DAC |
| dac_code | output | RES_W | Trial code to the DAC |
| plus_en | output | NUM_CH | One-hot positive input enable |
| minus_en | output | NUM_CH | One-hot negative input enable |
| minus_com | output | 1 | Negative input taken from the common terminal |
| do_o | output | 1 | Serial data output value |
| do_oe | output | 1 | Data output enable |
| sars_o | output | 1 | Conversion busy |
| sars_oe | output | 1 | Busy output enable |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | RES_W | Parallel conversion result |

## Verification
A wrong address capture shows at the input enables one cycle after the last address bit. It then propagates to every decided bit, because the bench comparator reads the channel that the enables select. A fault in the approximation register shows on the trial code in the very next cycle, and on the serial output one cycle after that. Faults in the replay shifter or in abort handling show as a wrong serial bit, or as an enable still high, in the first cycle they affect. This is why the bench compares the serial output, both enables and the trial code against its expectations on every clock of each frame.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_CONV,
        ST_SHIFT,
        ST_TAIL
    } seq_state_e;

    // Registered pin-side values of the serial port.
    typedef struct packed {
        logic do_val;
        logic do_oe;
        logic sars;
        logic sars_oe;
        logic done;
    } pin_reg_t;

    // Address: mode bit, odd bit, then log2(num_ch)-1 select bits.
    function automatic int addr_width(input int num_ch);
        return 1 + $clog2(num_ch);
    endfunction

    function automatic int sel_width(input int num_ch);
        return $clog2(num_ch) - 1;
    endfunction

endpackage

// File: rtl/adc_addr_decode.sv
`timescale 1ns/1ps
module adc_addr_decode
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              dec_en,
    input  logic              di,
    output logic [NUM_CH-1:0] plus_en,
    output logic [NUM_CH-1:0] minus_en,
    output logic              minus_com
);
    localparam int AW = addr_width(NUM_CH);
    localparam int SW = sel_width(NUM_CH);
    localparam int CW = $clog2(NUM_CH);

    logic [AW-1:0] addr_q;
    logic          single;
    logic          odd;
    logic [SW-1:0] sel;
    logic [CW-1:0] pidx;
    logic [CW-1:0] midx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_q <= '0;
        end else if (shift_en) begin
            addr_q <= {addr_q[AW-2:0], di};
        end
    end

    assign single = addr_q[AW-1];
    assign odd    = addr_q[AW-2];
    assign sel    = addr_q[SW-1:0];
    assign pidx   = {sel, odd};
    assign midx   = {sel, ~odd};

    always_comb begin
        plus_en   = '0;
        minus_en  = '0;
        minus_com = 1'b0;
        if (dec_en) begin
            plus_en[pidx] = 1'b1;
            if (single) begin
                minus_com = 1'b1;
            end else begin
                minus_en[midx] = 1'b1;
            end
        end
    end

    // R3: exactly one positive input, negative side never overlaps it
    assert_decode_pair_R3: assert property (@(posedge clk) disable iff (rst)
        dec_en |-> ($onehot(plus_en) && ((plus_en & minus_en) == '0)
                    && (minus_com != (|minus_en))));

    // R4: address is frozen outside the capture phase
    assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clr) |=> $stable(addr_q));

endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic             step,
    input  logic             comp,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] resolved,
    output logic             last
);
    localparam int IW = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] code_q;
    logic [IW-1:0]    idx_q;
    logic             active_q;
    logic [RES_W-1:0] trial_bit;

    assign trial_bit = active_q ? (RES_W'(1) << idx_q) : '0;
    assign dac_code  = code_q | trial_bit;
    assign resolved  = comp ? dac_code : code_q;
    assign last      = active_q && (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q   <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            code_q   <= '0;
            idx_q    <= IW'(RES_W - 1);
            active_q <= 1'b1;
        end else if (step && active_q) begin
            code_q <= resolved;
            if (idx_q == '0) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    // R5: the first trial is the MSB alone
    assert_first_trial_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !clr) |=> (dac_code == (RES_W'(1) << (RES_W - 1))));

    // R5: a bit accepted by the comparator stays in the code
    assert_trial_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (step && active_q && comp && !clr && !start)
        |=> ((dac_code & $past(dac_code)) == $past(dac_code)));

endmodule

// File: rtl/adc_out_shift.sv
`timescale 1ns/1ps
module adc_out_shift #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic [RES_W-1:0] code,
    output logic             bit_o,
    output logic             empty
);
    localparam int CW = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            // bit 0 already went out as the last MSB-first bit
            sh_q  <= code >> 1;
            cnt_q <= CW'(RES_W - 1);
        end else if (step) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign bit_o = sh_q[0];
    assign empty = (cnt_q == '0);

    // R8: never shifts past the end of the replay
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        step |-> !empty);

endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              di,
    input  logic              se,
    input  logic              comp,
    output logic [RES_W-1:0]  dac_code,
    output logic [NUM_CH-1:0] plus_en,
    output logic [NUM_CH-1:0] minus_en,
    output logic              minus_com,
    output logic              do_o,
    output logic              do_oe,
    output logic              sars_o,
    output logic              sars_oe,
    output logic              done,
    output logic [RES_W-1:0]  result
);
    localparam int   AW     = addr_width(NUM_CH);
    localparam int   CNT_W  = $clog2(AW);
    localparam logic USE_SE = (NUM_CH == 8);

    seq_state_e       st_q;
    pin_reg_t         pin_q;
    logic [CNT_W-1:0] acnt_q;
    logic             addr_valid_q;
    logic             started_q;
    logic [RES_W-1:0] result_q;

    logic             shift_en;
    logic             sar_start;
    logic             sar_step;
    logic             sar_last;
    logic [RES_W-1:0] sar_resolved;
    logic             hold;
    logic             sh_load;
    logic             sh_step;
    logic             sh_bit;
    logic             sh_empty;

    assign shift_en  = (st_q == ST_ADDR) && !cs_n;
    assign sar_start = (st_q == ST_SETTLE) && !cs_n;
    assign sar_step  = (st_q == ST_CONV) && !cs_n;
    assign hold      = USE_SE && se && !started_q;
    assign sh_load   = sar_step && sar_last;
    assign sh_step   = (st_q == ST_SHIFT) && !cs_n && !hold && !sh_empty;

    adc_addr_decode #(.NUM_CH(NUM_CH)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .clr       (cs_n),
        .shift_en  (shift_en),
        .dec_en    (addr_valid_q),
        .di        (di),
        .plus_en   (plus_en),
        .minus_en  (minus_en),
        .minus_com (minus_com)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .clr      (cs_n),
        .start    (sar_start),
        .step     (sar_step),
        .comp     (comp),
        .dac_code (dac_code),
        .resolved (sar_resolved),
        .last     (sar_last)
    );

    adc_out_shift #(.RES_W(RES_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (cs_n),
        .load  (sh_load),
        .step  (sh_step),
        .code  (sar_resolved),
        .bit_o (sh_bit),
        .empty (sh_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            pin_q        <= '0;
            acnt_q       <= '0;
            addr_valid_q <= 1'b0;
            started_q    <= 1'b0;
            result_q     <= '0;
        end else begin
            pin_q.done    <= 1'b0;
            pin_q.sars_oe <= !cs_n;
            if (cs_n) begin
                st_q         <= ST_IDLE;
                pin_q.do_val <= 1'b0;
                pin_q.do_oe  <= 1'b0;
                pin_q.sars   <= 1'b0;
                acnt_q       <= '0;
                addr_valid_q <= 1'b0;
                started_q    <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (di) begin
                            st_q   <= ST_ADDR;
                            acnt_q <= '0;
                        end
                    end
                    ST_ADDR: begin
                        if (acnt_q == CNT_W'(AW - 1)) begin
                            st_q         <= ST_SETTLE;
                            addr_valid_q <= 1'b1;
                        end else begin
                            acnt_q <= acnt_q + 1'b1;
                        end
                    end
                    ST_SETTLE: begin
                        st_q       <= ST_CONV;
                        pin_q.sars <= 1'b1;
                    end
                    ST_CONV: begin
                        pin_q.do_val <= comp;
                        pin_q.do_oe  <= 1'b1;
                        if (sar_last) begin
                            pin_q.sars <= 1'b0;
                            pin_q.done <= 1'b1;
                            result_q   <= sar_resolved;
                            st_q       <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (!hold) begin
                            started_q <= 1'b1;
                            if (sh_empty) begin
                                pin_q.do_val <= 1'b0;
                                st_q         <= ST_TAIL;
                            end else begin
                                pin_q.do_val <= sh_bit;
                            end
                        end
                    end
                    ST_TAIL: begin
                        pin_q.do_val <= 1'b0;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign do_o    = pin_q.do_val;
    assign do_oe   = pin_q.do_oe;
    assign sars_o  = pin_q.sars;
    assign sars_oe = pin_q.sars_oe;
    assign done    = pin_q.done;
    assign result  = result_q;

    // R10: select high releases both outputs on the next cycle
    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!do_oe && !sars_oe && !sars_o));

    // R7: done coincides with the end of busy
    assert_done_end_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(sars_o) && !sars_o));

    // R9: the tail phase keeps the data output low
    assert_tail_low_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAIL) |-> !do_o);

    // R4: busy is only shown while its enable is high
    assert_busy_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        sars_o |-> sars_oe);

endmodule

// File: tb/tb_adc_serial_seq.sv
`timescale 1ns/1ps
module tb_adc_serial_seq;
    localparam int NUM_CH = 8;
    localparam int RES_W  = 8;
    localparam int AW     = 1 + $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic              di = 1'b0;
    logic              se = 1'b0;
    logic              comp;
    logic [RES_W-1:0]  dac_code;
    logic [NUM_CH-1:0] plus_en;
    logic [NUM_CH-1:0] minus_en;
    logic              minus_com;
    logic              do_o;
    logic              do_oe;
    logic              sars_o;
    logic              sars_oe;
    logic              done;
    logic [RES_W-1:0]  result;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int vch [NUM_CH];
    int vcom;
    int vp;
    int vm;

    always #2.5 clk = ~clk;

    adc_serial_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .di(di), .se(se), .comp(comp),
        .dac_code(dac_code), .plus_en(plus_en), .minus_en(minus_en),
        .minus_com(minus_com), .do_o(do_o), .do_oe(do_oe), .sars_o(sars_o),
        .sars_oe(sars_oe), .done(done), .result(result)
    );

    // Analogue side: selector plus comparator
    always_comb begin
        vp = 0;
        vm = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (plus_en[i]) vp = vch[i];
            if (minus_en[i]) vm = vch[i];
        end
        if (minus_com) vm = vcom;
        comp = ((vp - vm) >= int'(dac_code));
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check_released(input string tag);
        chk({tag, " R10 do_oe"}, 32'(do_oe), 0);
        chk({tag, " R10 sars_oe"}, 32'(sars_oe), 0);
        chk({tag, " R10 sars"}, 32'(sars_o), 0);
        chk({tag, " R10 plus_en"}, 32'(plus_en), 0);
    endtask

    // One full frame; abort_k >= 0 raises select before conversion step abort_k
    task automatic run_frame(input bit single, input bit odd, input int sel,
                             input int lead, input int se_hold, input int abort_k,
                             input string tag);
        int pidx;
        int midx;
        int vdiff;
        int expv;
        int trial;
        bit ab;
        pidx  = sel * 2 + int'(odd);
        midx  = sel * 2 + int'(!odd);
        vdiff = vch[pidx] - (single ? vcom : vch[midx]);
        expv  = (vdiff < 0) ? 0 : ((vdiff > 255) ? 255 : vdiff);

        cs_n = 1'b0;
        di   = 1'b0;
        se   = 1'b0;
        for (int i = 0; i < lead; i++) begin
            tick();
            chk({tag, " R2 idle oe"}, 32'(do_oe), 0);
            chk({tag, " R2 idle sars"}, 32'(sars_o), 0);
        end
        di = 1'b1;
        tick();
        chk({tag, " R2 sars_oe"}, 32'(sars_oe), 1);
        for (int k = 0; k < AW; k++) begin
            if (k == 0) ab = single;
            else if (k == 1) ab = odd;
            else ab = sel[AW-1-k];
            di = ab;
            tick();
        end
        chk({tag, " R3 plus_en"}, 32'(plus_en), 32'(1) << pidx);
        chk({tag, " R3 minus_en"}, 32'(minus_en), single ? 0 : (32'(1) << midx));
        chk({tag, " R3 minus_com"}, 32'(minus_com), 32'(single));
        chk({tag, " R4 settle busy"}, 32'(sars_o), 0);
        di = 1'b1;
        tick();
        chk({tag, " R4 busy"}, 32'(sars_o), 1);
        chk({tag, " R6 oe before"}, 32'(do_oe), 0);
        for (int k = 0; k < RES_W; k++) begin
            trial = (expv & ~((1 << (RES_W - k)) - 1)) | (1 << (RES_W - 1 - k));
            chk({tag, " R5 trial"}, 32'(dac_code), 32'(trial));
            di = 1'($urandom);
            if (k == abort_k) begin
                cs_n = 1'b1;
                tick();
                check_released(tag);
                return;
            end
            tick();
            chk({tag, " R6 do_oe"}, 32'(do_oe), 1);
            chk({tag, " R6 msb-first bit"}, 32'(do_o), 32'((expv >> (RES_W - 1 - k)) & 1));
            chk({tag, " R4 busy span"}, 32'(sars_o), (k < RES_W - 1) ? 1 : 0);
            chk({tag, " R7 done"}, 32'(done), (k == RES_W - 1) ? 1 : 0);
        end
        chk({tag, " R7 result"}, 32'(result), 32'(expv));
        if (se_hold > 0) se = 1'b1;
        for (int h = 0; h < se_hold; h++) begin
            tick();
            chk({tag, " R8 hold lsb"}, 32'(do_o), 32'(expv & 1));
        end
        se = 1'b0;
        for (int j = 1; j < RES_W; j++) begin
            tick();
            chk({tag, " R8 lsb-first bit"}, 32'(do_o), 32'((expv >> j) & 1));
        end
        for (int t = 0; t < 3; t++) begin
            tick();
            chk({tag, " R9 tail low"}, 32'(do_o), 0);
            chk({tag, " R9 tail oe"}, 32'(do_oe), 1);
        end
        cs_n = 1'b1;
        tick();
        check_released(tag);
    endtask

    initial begin
        vch[0] = 200; vch[1] = 37;  vch[2] = 255; vch[3] = 0;
        vch[4] = 128; vch[5] = 129; vch[6] = 90;  vch[7] = 91;
        vcom = 10;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 dac_code", 32'(dac_code), 0);
        chk("R1 enables", 32'({plus_en, minus_en, minus_com}), 0);
        chk("R1 pins", 32'({do_o, do_oe, sars_o, sars_oe, done}), 0);
        chk("R1 result", 32'(result), 0);

        run_frame(1, 0, 0, 2, 3, -1, "single ch0");   // 190
        run_frame(0, 0, 1, 0, 0, -1, "diff 2-3");     // 255
        run_frame(0, 1, 1, 1, 1, -1, "diff 3-2");     // negative -> 0 (R7)
        run_frame(0, 1, 2, 3, 0, -1, "diff 5-4");     // 1
        run_frame(1, 1, 3, 0, 2, -1, "single ch7");   // 81
        run_frame(0, 1, 2, 0, 0, 3, "abort conv");
        tick();
        run_frame(1, 1, 0, 1, 0, -1, "after abort");  // 27

        // R10: abort inside the address phase, then a clean frame
        cs_n = 1'b0;
        di = 1'b1;
        tick();
        di = 1'b0;
        tick();
        cs_n = 1'b1;
        tick();
        check_released("abort addr");
        tick();
        run_frame(0, 0, 3, 2, 0, -1, "after addr abort"); // 90-91 -> 0

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule